// File: doc/BRIEF.md
# Serial-Port Power-Mode Controller for a Sampling Converter

This block models the digital side of a converter's serial read-out port. An active-low select and a serial clock come in asynchronously and are resynchronized into a faster system clock. Each low period of the select opens a frame. During the frame the block shifts a 16-bit word out on a data line that can be three-stated: zero-valued pad bits first, then a sample taken from a parallel input, most significant bit first. The parallel input stands in for the converter core.

The same port also controls power. The number of serial clock falling edges counted before the select returns high decides the next power state. A short frame that stops in a middle window sends the block to sleep. A frame that runs long enough while asleep wakes it again, but the word read in that wake frame is a dummy. A settle timer and a quiet-time timer, both counted in system clocks, decide whether a later full frame is reported as valid and whether a frame started too early is flagged.

Top module: `spm_top`

## Requirements
- R1: The frame is 16 bits long: four 0 bits, then `sample_i[11:0]` MSB first. Bit 15 is on `sdata_o` once a select falling edge has been seen, and each counted serial-clock falling edge moves to the next lower bit.
- R2: `sdata_oe_o` is 1 only inside a frame. It goes to 0 on the select rising edge, or after the 16th serial-clock falling edge, whichever comes first.
- R3: While powered, a select rising edge after fewer than 2 falling edges leaves `powered_o` at 1.
- R4: While powered, a select rising edge after 2 to 9 falling edges sets `powered_o` to 0.
- R5: While powered, a select rising edge after 10 or more falling edges leaves `powered_o` at 1. A frame cut short before 16 edges gives no valid pulse.
- R6: While asleep, a select rising edge after fewer than 10 falling edges leaves `powered_o` at 0.
- R7: While asleep, the 10th falling edge of a frame sets `powered_o` to 1. That frame never gives a valid pulse.
- R8: `data_valid_o` pulses for one cycle at the end of a full 16-edge frame only if the frame started while powered and at least PWRUP_CYC system cycles after the last wake-up.
- R9: `quiet_viol_o` pulses when a select falling edge comes within QUIET_CYC system cycles of the data line being released.
- R10: After reset, `powered_o` is 1 and `sdata_oe_o`, `data_valid_o` and `quiet_viol_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| sample_i | input | 12 | Sample value loaded at frame start |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Drive enable for the data line (0 = high-Z) |
| powered_o | output | 1 | 1 when the block is powered |
| data_valid_o | output | 1 | One-cycle pulse at the end of a valid full frame |
| quiet_viol_o | output | 1 | One-cycle pulse on a frame started too early |

## Verification
The assertions assume that each level on `cs_n` and `sclk` lasts several system clocks. They also assume that a select edge and a serial-clock edge never land in the same synchronized cycle, so every edge is seen exactly once and in its own cycle. The stimulus holds each level for four system clocks and leaves four more clocks between a select change and any serial-clock change. Frame gaps are chosen well clear of the quiet and settle limits, so each expected flag is unambiguous.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    PM_ON   = 2'd0,
    PM_OFF  = 2'd1,
    PM_WAKE = 2'd2
  } pm_state_t;
endpackage

// File: rtl/spm_edge_sync.sv
module spm_edge_sync #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // two synchronizing stages plus one history stage for edge detection
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {3{INIT}};
    else     pipe_q <= {pipe_q[1:0], d_i};
  end

  assign rise_o = pipe_q[1] & ~pipe_q[2];
  assign fall_o = ~pipe_q[1] & pipe_q[2];
endmodule

// File: rtl/spm_shifter.sv
module spm_shifter #(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              in_frame_o,
  output logic              step_o,
  output logic              sdata_o,
  output logic              sdata_en_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 in_frame_q;
  logic                 en_q;

  assign step_o = in_frame_q && sclk_fall_i && !cs_rise_i && (cnt_q < FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (cs_fall_i) begin
      sh_q       <= FRAME_LEN'(sample_i);
      cnt_q      <= '0;
      in_frame_q <= 1'b1;
      en_q       <= 1'b1;
    end else if (cs_rise_i) begin
      in_frame_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (step_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
      sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
      if (cnt_q == LAST) en_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign in_frame_o = in_frame_q;
  assign sdata_o    = sh_q[FRAME_LEN-1];
  assign sdata_en_o = en_q;

  assert_frame_open_R1: assert property (@(posedge clk) disable iff (rst)
    cs_fall_i |=> (en_q && cnt_q == '0));
  assert_release_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    cs_rise_i |=> !en_q);
  assert_release_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    (step_o && cnt_q == LAST) |=> !en_q);
endmodule

// File: rtl/spm_power_ctrl.sv
module spm_power_ctrl
  import spm_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int DOWN_EDGE = 2,
  parameter int WAKE_EDGE = 10,
  parameter int QUIET_CYC = 8,
  parameter int PWRUP_CYC = 100,
  parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             in_frame_i,
  input  logic             sdata_en_i,
  output logic             powered_o,
  output logic             valid_o,
  output logic             viol_o
);
  localparam int PU_W = $clog2(PWRUP_CYC + 1);
  localparam int Q_W  = $clog2(QUIET_CYC + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] DN_LO  = CNT_W'(DOWN_EDGE);
  localparam logic [CNT_W-1:0] UP_LO  = CNT_W'(WAKE_EDGE);
  localparam logic [CNT_W-1:0] WK_HIT = CNT_W'(WAKE_EDGE - 1);

  pm_state_t       state_q;
  logic [PU_W-1:0] pu_q;
  logic [Q_W-1:0]  quiet_q;
  logic            ok_q, valid_q, viol_q;
  logic            release_w;

  assign release_w = sdata_en_i && (cs_rise_i || (step_i && cnt_i == LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_ON;
      pu_q    <= '0;
      quiet_q <= '0;
      ok_q    <= 1'b0;
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
      if (pu_q != '0) pu_q <= pu_q - PU_W'(1);
      if (release_w)  quiet_q <= Q_W'(QUIET_CYC);
      else if (quiet_q != '0) quiet_q <= quiet_q - Q_W'(1);
      if (cs_fall_i) begin
        viol_q <= (quiet_q != '0);
        ok_q   <= (state_q == PM_ON) && (pu_q == '0);
      end
      if (step_i && cnt_i == LAST) valid_q <= ok_q;
      unique case (state_q)
        PM_ON: begin
          if (cs_rise_i && in_frame_i && cnt_i >= DN_LO && cnt_i < UP_LO)
            state_q <= PM_OFF;
        end
        PM_OFF: begin
          if (cs_fall_i) state_q <= PM_WAKE;
        end
        PM_WAKE: begin
          if (cs_rise_i) begin
            state_q <= PM_OFF;
          end else if (step_i && cnt_i == WK_HIT) begin
            state_q <= PM_ON;
            pu_q    <= PU_W'(PWRUP_CYC);
            ok_q    <= 1'b0;
          end
        end
        default: state_q <= PM_ON;
      endcase
    end
  end

  assign powered_o = (state_q == PM_ON);
  assign valid_o   = valid_q;
  assign viol_o    = viol_q;

  assert_glitch_stays_on_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_ON && cs_rise_i && cnt_i < DN_LO) |=> state_q == PM_ON);
  assert_late_abort_on_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_ON && cs_rise_i && cnt_i >= UP_LO) |=> state_q == PM_ON);
  assert_early_rise_sleeps_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_WAKE && cs_rise_i) |=> state_q == PM_OFF);
  assert_valid_only_on_R8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (state_q == PM_ON && pu_q == '0));
  assert_quiet_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_fall_i && quiet_q != '0) |=> viol_q);
endmodule

// File: rtl/spm_top.sv
module spm_top #(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 16,
  parameter int DOWN_EDGE = 2,
  parameter int WAKE_EDGE = 10,
  parameter int QUIET_CYC = 8,
  parameter int PWRUP_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              powered_o,
  output logic              data_valid_o,
  output logic              quiet_viol_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int N_IN  = 2;   // channel 0: select, channel 1: serial clock

  logic [N_IN-1:0] raw_w, rise_w, fall_w;
  logic [CNT_W-1:0] cnt_w;
  logic in_frame_w, step_w;

  assign raw_w = {sclk, cs_n};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    spm_edge_sync #(.INIT(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d_i(raw_w[g]),
      .rise_o(rise_w[g]), .fall_o(fall_w[g])
    );
  end

  spm_shifter #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_fall_i(fall_w[0]), .cs_rise_i(rise_w[0]), .sclk_fall_i(fall_w[1]),
    .sample_i(sample_i), .cnt_o(cnt_w), .in_frame_o(in_frame_w),
    .step_o(step_w), .sdata_o(sdata_o), .sdata_en_o(sdata_oe_o)
  );

  spm_power_ctrl #(
    .FRAME_LEN(FRAME_LEN), .DOWN_EDGE(DOWN_EDGE), .WAKE_EDGE(WAKE_EDGE),
    .QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC), .CNT_W(CNT_W)
  ) u_pwr (
    .clk(clk), .rst(rst),
    .cs_fall_i(fall_w[0]), .cs_rise_i(rise_w[0]), .step_i(step_w),
    .cnt_i(cnt_w), .in_frame_i(in_frame_w), .sdata_en_i(sdata_oe_o),
    .powered_o(powered_o), .valid_o(data_valid_o), .viol_o(quiet_viol_o)
  );

  // rise_w[1] is used only through the generate loop; unused otherwise by design
  logic unused_w;
  assign unused_w = rise_w[1];
endmodule

// File: tb/tb_spm_top.sv
module tb_spm_top;
  localparam int CLK_PERIOD = 10;
  localparam int QUIET = 8;
  localparam int PU    = 100;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b1;
  logic [11:0] sample = '0;
  logic sdata, oe, powered, dvalid, qviol;

  int checks = 0, errors = 0, cyc = 0, vcnt = 0, qcnt = 0;
  int rel_cyc = -1000, commit_cyc = -100000;
  bit m_down = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && dvalid) vcnt <= vcnt + 1;
    if (!rst && qviol)  qcnt <= qcnt + 1;
  end

  spm_top #(.QUIET_CYC(QUIET), .PWRUP_CYC(PU)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample_i(sample),
    .sdata_o(sdata), .sdata_oe_o(oe), .powered_o(powered),
    .data_valid_o(dvalid), .quiet_viol_o(qviol)
  );

  function automatic logic fbit(input logic [11:0] s, input int idx);
    logic [15:0] f;
    f = {4'b0000, s};
    return f[idx];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait4();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_frame(input int n, input logic [11:0] smp, input int gap);
    int v0, q0, fall_cyc;
    bit start_down, ready, exp_viol;
    while ((cyc - rel_cyc) < gap) @(negedge clk);
    exp_viol = (cyc - rel_cyc) <= QUIET;
    v0 = vcnt; q0 = qcnt;
    start_down = m_down;
    fall_cyc = cyc;
    ready = !start_down && ((fall_cyc - commit_cyc) >= PU + 1);
    sample = smp;
    cs_n = 1'b0;
    wait4();
    chk("R2 oe at frame start", oe, 1);
    chk("R1 first bit", sdata, fbit(smp, 15));
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b0;
      if (k == 10 && start_down) commit_cyc = cyc;
      if (k == 16) rel_cyc = cyc;
      wait4();
      if (k < 16) begin
        chk("R2 oe mid frame", oe, 1);
        chk("R1 frame bit", sdata, fbit(smp, 15 - k));
      end else begin
        chk("R2 oe after 16th edge", oe, 0);
      end
      if (start_down && k == 9)  chk("R7 still asleep before 10th", powered, 0);
      if (start_down && k == 10) chk("R7 awake at 10th", powered, 1);
      sclk = 1'b1;
      wait4();
    end
    cs_n = 1'b1;
    if (n < 16) rel_cyc = cyc;
    wait4();
    chk("R2 oe after select rise", oe, 0);
    if (!start_down) begin
      if (n >= 2 && n < 10) m_down = 1'b1;
    end else if (n >= 10) begin
      m_down = 1'b0;
    end
    if (!start_down) begin
      if (n < 2)       chk("R3 powered", powered, 1);
      else if (n < 10) chk("R4 powered", powered, 0);
      else             chk("R5 powered", powered, 1);
    end else begin
      if (n < 10) chk("R6 powered", powered, 0);
      else        chk("R7 powered", powered, 1);
    end
    if (start_down)   chk("R7 no valid on wake frame", vcnt - v0, 0);
    else if (n < 16)  chk("R5 no valid on short frame", vcnt - v0, 0);
    else              chk("R8 valid pulses", vcnt - v0, (ready ? 1 : 0));
    chk("R9 quiet violation", qcnt - q0, (exp_viol ? 1 : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, gap;
    bit was_wake;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset powered", powered, 1);
    chk("R10 reset oe", oe, 0);
    chk("R10 reset valid", dvalid, 0);
    chk("R10 reset viol", qviol, 0);
    do_frame(16, 12'hABC, 20);   // R1 R8 full valid frame
    do_frame(1,  12'h123, 20);   // R3 glitch
    do_frame(2,  12'h456, 20);   // R4 sleep at lower bound
    do_frame(5,  12'h789, 20);   // R6 failed wake
    do_frame(10, 12'hFFF, 20);   // R7 wake at 10th edge
    do_frame(16, 12'h5A5, 20);   // R8 too soon after wake
    do_frame(16, 12'h3C3, 150);  // R8 settled
    do_frame(12, 12'h0F0, 20);   // R5 late abort
    do_frame(9,  12'h111, 20);   // R4 upper bound
    do_frame(16, 12'h222, 150);  // R7 wake with full dummy frame
    do_frame(16, 12'h800, 150);  // R8
    do_frame(16, 12'h001, 5);    // R9 early start
    do_frame(0,  12'h777, 20);   // R3 no edges
    was_wake = 1'b0;
    for (int i = 0; i < 40; i++) begin
      n = $urandom % 19;
      if (was_wake)               gap = 150 + ($urandom % 20);
      else if ($urandom % 4 == 0) gap = 5 + ($urandom % 2);
      else                        gap = 11 + ($urandom % 20);
      was_wake = m_down && (n >= 10);
      do_frame(n, 12'($urandom), gap);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule